// File: doc/BRIEF.md
# Slot Protocol MAC Timer

This block keeps time for a radio that works in time slots. A 16-bit base counter runs from zero up to a programmable period and then starts again from zero. An 8-bit period counter records how many full periods have gone by. Software sets the period, the compare time and the command in a small register file. Software can also load the base counter and the period counter directly, so that a slot boundary lines up with a received beacon.

Two event inputs mark radio activity: the frame-start-delimiter detect and the end of a transmission. A control bit chooses one of them. The rising edge of the chosen event stamps the base count into a capture register and raises a flag. A compare register names a count value, and it can also require a period count. When the time matches, the block sends the radio controller a one-cycle command strobe that carries a 3-bit command code, such as start receive or start transmit. The strobe is a plain event pulse with no ready signal. The radio controller must accept it in the cycle it is asserted, because the block cannot hold a command back or queue one.

Top module: `slot_timer`

## Requirements
- R1: After reset the base count, the period count, the capture value and the capture flag read as zero, the period register reads 0xFFFF, and strobe_valid is low.
- R2: While the run bit (control bit 0) is 1, the base count rises by one each cycle. While it is 0, the base count and the period count hold their values.
- R3: When the base count is running and equals the period register, the next cycle gives a base count of 0 and adds one to the period count. The period count wraps from 255 to 0.
- R4: A write to the count address (4) or the period-count address (5) loads that counter, and the load wins over counting in the same cycle.
- R5: Control bit 1 selects the capture source (0 = frame-start input, 1 = transmit-end input). A rising edge of that source stores the base count of the edge cycle in the capture register (address 6) and sets the flag (status bit 0, address 7). Both are readable in the next cycle.
- R6: A source that is not selected, or a selected source that stays high, does not change the capture register or the flag.
- R7: Writing 1 to status bit 0 clears the flag. A capture in the same cycle wins, and the flag stays set.
- R8: While the timer is running, a cycle whose base count equals the compare register (address 2) makes strobe_valid high in the next cycle for one cycle per match. In that cycle strobe_cmd carries control bits 6:4.
- R9: When control bit 2 is set, a match also requires the period count to equal the period-compare register (address 3).
- R10: No strobe is issued while the run bit is 0.
- R11: Register addresses are: 0 period, 1 control, 2 compare, 3 period-compare, 4 count, 5 period count, 6 capture (read only), 7 status. Reads are combinational from rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| sfd_in | input | 1 | Frame-start-delimiter event, synchronous |
| txend_in | input | 1 | Transmit-end event, synchronous |
| strobe_valid | output | 1 | One-cycle command strobe |
| strobe_cmd | output | 3 | Command code sent with the strobe |

## Verification
A register write takes effect at the clock edge that samples it. The bench therefore drives each write at a falling edge and reads the result at the next falling edge, when the run bit, a loaded count or a cleared flag is already visible. After the run bit is set, the bench counts falling edges m from that point and predicts base count m mod (P+1) and period count m div (P+1). It predicts strobe_valid one cycle after the cycle whose base count equals the compare value. A capture appears one edge after the event input rises and holds the count read just before that edge. Every window is sampled at each falling edge, so a strobe that comes one cycle early or late is counted as a mismatch.

// File: rtl/slot_tmr_pkg.sv
package slot_tmr_pkg;
  localparam int unsigned CMD_W = 3;

  typedef enum logic [2:0] {
    RA_PERIOD  = 3'd0,
    RA_CTRL    = 3'd1,
    RA_CMP     = 3'd2,
    RA_OVF_CMP = 3'd3,
    RA_COUNT   = 3'd4,
    RA_OVF     = 3'd5,
    RA_CAPT    = 3'd6,
    RA_STATUS  = 3'd7
  } reg_addr_e;

  // control word: command code in 6:4, spare bit 3, qualify/source/run below
  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic             spare;
    logic             ovq;
    logic             src;
    logic             run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/slot_tmr_count.sv
module slot_tmr_count #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned OVF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  input  logic             ld_cnt,
  input  logic [CNT_W-1:0] ld_cnt_val,
  input  logic             ld_ovf,
  input  logic [OVF_W-1:0] ld_ovf_val,
  output logic [CNT_W-1:0] cnt,
  output logic [OVF_W-1:0] ovf
);
  logic wrap;
  assign wrap = run && (cnt == period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= '0;
    end else begin
      if (ld_cnt)      cnt <= ld_cnt_val;
      else if (wrap)   cnt <= '0;
      else if (run)    cnt <= cnt + 1'b1;

      if (ld_ovf)      ovf <= ld_ovf_val;
      else if (wrap)   ovf <= ovf + 1'b1;
    end
  end
endmodule

// File: rtl/slot_tmr_capture.sv
module slot_tmr_capture #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] ev,
  input  logic [$clog2(N_SRC)-1:0] sel,
  input  logic [CNT_W-1:0] cnt,
  input  logic             clr,
  output logic             hit,
  output logic [CNT_W-1:0] cap,
  output logic             cap_valid
);
  logic [N_SRC-1:0] rise;

  for (genvar g = 0; g < N_SRC; g++) begin : g_edge
    logic prev;
    always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= ev[g];
    end
    assign rise[g] = ev[g] & ~prev;
  end

  assign hit = rise[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap       <= '0;
      cap_valid <= 1'b0;
    end else begin
      if (hit) begin
        cap       <= cnt;
        cap_valid <= 1'b1;
      end else if (clr) begin
        cap_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slot_tmr_strobe.sv
module slot_tmr_strobe #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned OVF_W   = 8,
  parameter int unsigned CMD_W   = 3,
  parameter bit          HAS_OVQ = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [OVF_W-1:0] ovf,
  input  logic [CNT_W-1:0] cmp,
  input  logic [OVF_W-1:0] ovf_cmp,
  input  logic             ovq,
  input  logic [CMD_W-1:0] cmd_in,
  output logic             strobe_valid,
  output logic [CMD_W-1:0] strobe_cmd
);
  logic qual_ok;
  logic match;

  if (HAS_OVQ) begin : g_ovq
    assign qual_ok = !ovq || (ovf == ovf_cmp);
  end else begin : g_no_ovq
    assign qual_ok = 1'b1;
  end

  assign match = run && (cnt == cmp) && qual_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_valid <= 1'b0;
      strobe_cmd   <= '0;
    end else begin
      strobe_valid <= match;
      if (match) strobe_cmd <= cmd_in;
    end
  end
endmodule

// File: rtl/slot_timer.sv
module slot_timer
  import slot_tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned OVF_W       = 8,
  parameter bit          OVF_QUAL_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             sfd_in,
  input  logic             txend_in,
  output logic             strobe_valid,
  output logic [CMD_W-1:0] strobe_cmd
);
  localparam int unsigned N_SRC = 2;

  logic [CNT_W-1:0] period_q, cmp_q;
  logic [OVF_W-1:0] ovf_cmp_q;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt, cap;
  logic [OVF_W-1:0] ovf;
  logic             cap_valid, hit;
  logic             ld_cnt, ld_ovf, clr_flag;
  reg_addr_e        wa;

  assign wa       = reg_addr_e'(wr_addr);
  assign ld_cnt   = wr_en && (wa == RA_COUNT);
  assign ld_ovf   = wr_en && (wa == RA_OVF);
  assign clr_flag = wr_en && (wa == RA_STATUS) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q  <= '1;
      cmp_q     <= '0;
      ovf_cmp_q <= '0;
      ctrl_q    <= '0;
    end else if (wr_en) begin
      case (wa)
        RA_PERIOD:  period_q  <= wr_data;
        RA_CTRL:    ctrl_q    <= ctrl_t'(wr_data[CTRL_W-1:0]);
        RA_CMP:     cmp_q     <= wr_data;
        RA_OVF_CMP: ovf_cmp_q <= wr_data[OVF_W-1:0];
        default:    ;
      endcase
    end
  end

  slot_tmr_count #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl_q.run),
    .period     (period_q),
    .ld_cnt     (ld_cnt),
    .ld_cnt_val (wr_data),
    .ld_ovf     (ld_ovf),
    .ld_ovf_val (wr_data[OVF_W-1:0]),
    .cnt        (cnt),
    .ovf        (ovf)
  );

  slot_tmr_capture #(.CNT_W(CNT_W), .N_SRC(N_SRC)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        ({txend_in, sfd_in}),
    .sel       (ctrl_q.src),
    .cnt       (cnt),
    .clr       (clr_flag),
    .hit       (hit),
    .cap       (cap),
    .cap_valid (cap_valid)
  );

  slot_tmr_strobe #(
    .CNT_W(CNT_W), .OVF_W(OVF_W), .CMD_W(CMD_W), .HAS_OVQ(OVF_QUAL_EN)
  ) u_strobe (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (ctrl_q.run),
    .cnt          (cnt),
    .ovf          (ovf),
    .cmp          (cmp_q),
    .ovf_cmp      (ovf_cmp_q),
    .ovq          (ctrl_q.ovq),
    .cmd_in       (ctrl_q.cmd),
    .strobe_valid (strobe_valid),
    .strobe_cmd   (strobe_cmd)
  );

  always_comb begin
    case (reg_addr_e'(rd_addr))
      RA_PERIOD:  rd_data = period_q;
      RA_CTRL:    rd_data = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      RA_CMP:     rd_data = cmp_q;
      RA_OVF_CMP: rd_data = {{(CNT_W-OVF_W){1'b0}}, ovf_cmp_q};
      RA_COUNT:   rd_data = cnt;
      RA_OVF:     rd_data = {{(CNT_W-OVF_W){1'b0}}, ovf};
      RA_CAPT:    rd_data = cap;
      default:    rd_data = {{(CNT_W-1){1'b0}}, cap_valid};
    endcase
  end
endmodule

// File: rtl/slot_timer_chk.sv
module slot_timer_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned OVF_W = 8,
  parameter int unsigned CMD_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             ovq,
  input logic [CMD_W-1:0] cmd,
  input logic [CNT_W-1:0] cnt,
  input logic [OVF_W-1:0] ovf,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] cmp,
  input logic [OVF_W-1:0] ovf_cmp,
  input logic             ld_cnt,
  input logic             ld_ovf,
  input logic             hit,
  input logic [CNT_W-1:0] cap,
  input logic             cap_valid,
  input logic             strobe_valid,
  input logic [CMD_W-1:0] strobe_cmd
);
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    run && !ld_cnt && (cnt == period) |=> cnt == '0);

  a_r3_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
    run && !ld_ovf && (cnt == period) |=> ovf == OVF_W'($past(ovf) + 1'b1));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !ld_cnt |=> $stable(cnt));

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cap_valid && (cap == $past(cnt)));

  a_r8_strobe_time: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_valid |-> $past(run) && ($past(cnt) == $past(cmp)));

  a_r8_strobe_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_valid |-> strobe_cmd == $past(cmd));

  a_r9_qualify: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_valid && $past(ovq) |-> $past(ovf) == $past(ovf_cmp));

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !strobe_valid);
endmodule

bind slot_timer slot_timer_chk #(.CNT_W(CNT_W), .OVF_W(OVF_W), .CMD_W(slot_tmr_pkg::CMD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run          (ctrl_q.run),
  .ovq          (ctrl_q.ovq),
  .cmd          (ctrl_q.cmd),
  .cnt          (cnt),
  .ovf          (ovf),
  .period       (period_q),
  .cmp          (cmp_q),
  .ovf_cmp      (ovf_cmp_q),
  .ld_cnt       (ld_cnt),
  .ld_ovf       (ld_ovf),
  .hit          (hit),
  .cap          (cap),
  .cap_valid    (cap_valid),
  .strobe_valid (strobe_valid),
  .strobe_cmd   (strobe_cmd)
);

// File: tb/test_slot_timer.sv
`timescale 1ns/1ps
module test_slot_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        sfd_in = 1'b0;
  logic        txend_in = 1'b0;
  logic        strobe_valid;
  logic [2:0]  strobe_cmd;
  int          n_tests = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  slot_timer i_slot_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sfd_in(sfd_in), .txend_in(txend_in),
    .strobe_valid(strobe_valid), .strobe_cmd(strobe_cmd)
  );

  function automatic int exp_cnt(int m, int p);
    return m % (p + 1);
  endfunction

  function automatic int exp_ovf(int m, int p, int o0);
    return (o0 + m / (p + 1)) % 256;
  endfunction

  function automatic bit exp_strobe(int m, int p, int c, bit q, int oc);
    if (m < 1) return 1'b0;
    if (exp_cnt(m - 1, p) != c) return 1'b0;
    if (q && exp_ovf(m - 1, p, 0) != oc) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    rd_addr = a;
    #1;
    d = int'(rd_data);
  endtask

  // starts from count 0, period count 0; returns at edge m=0 with run set
  task automatic start(input int p, input int c, input int cmd, input bit q, input int oc);
    wr(3'd1, 0);
    wr(3'd0, p);
    wr(3'd2, c);
    wr(3'd3, oc);
    wr(3'd4, 0);
    wr(3'd5, 0);
    wr(3'd1, (cmd << 4) | (int'(q) << 2) | 1);
  endtask

  task automatic window(input int p, input int c, input int cmd, input bit q,
                        input int oc, input int w, input string tag);
    int err = 0;
    int v;
    for (int m = 0; m <= w; m++) begin
      #1;
      if (strobe_valid !== exp_strobe(m, p, c, q, oc)) err++;
      else if (strobe_valid && strobe_cmd !== 3'(cmd)) err++;
      if (m == w) begin
        rd(3'd4, v); chk({tag, " R2 R3 count"}, v, exp_cnt(w, p));
        rd(3'd5, v); chk({tag, " R3 period count"}, v, exp_ovf(w, p, 0));
      end else begin
        @(negedge clk);
      end
    end
    chk({tag, " R8 R9 strobe mismatches"}, err, 0);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int v, v2, p, c, cmd;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R11: reset values
    rd(3'd4, v); chk("R1 count", v, 0);
    rd(3'd5, v); chk("R1 period count", v, 0);
    rd(3'd6, v); chk("R1 capture", v, 0);
    rd(3'd7, v); chk("R1 flag", v, 0);
    rd(3'd0, v); chk("R1 R11 period reg", v, 16'hFFFF);
    chk("R1 strobe", int'(strobe_valid), 0);
    repeat (5) @(negedge clk);
    rd(3'd4, v); chk("R2 stopped count", v, 0);

    // random periods and compare points
    for (int t = 0; t < 6; t++) begin
      p   = 3 + int'($urandom % 30);
      c   = int'($urandom % (p + 1));
      cmd = int'($urandom % 8);
      start(p, c, cmd, 1'b0, 0);
      window(p, c, cmd, 1'b0, 0, 3 * (p + 1) + 4, "rand");
    end

    // directed corners: compare at 0, compare at period
    start(5, 0, 6, 1'b0, 0);
    window(5, 0, 6, 1'b0, 0, 20, "cmp0");
    start(5, 5, 1, 1'b0, 0);
    window(5, 5, 1, 1'b0, 0, 20, "cmpP");

    // R9: period-count qualifier
    start(4, 2, 3, 1'b1, 2);
    window(4, 2, 3, 1'b1, 2, 5 * 5 + 3, "qual");

    // R2 / R10: stop, hold, no strobe even with compare at the held value
    wr(3'd1, 7 << 4);
    rd(3'd4, v);
    wr(3'd2, v);
    v2 = 0;
    for (int k = 0; k < 8; k++) begin
      #1; if (strobe_valid) v2++;
      @(negedge clk);
    end
    chk("R10 no strobe while stopped", v2, 0);
    rd(3'd4, v2); chk("R2 hold while stopped", v2, v);

    // R3: period-count wrap 255 -> 0
    wr(3'd0, 10);
    wr(3'd4, 10);
    wr(3'd5, 255);
    wr(3'd1, 1);
    rd(3'd5, v); chk("R4 period count load", v, 255);
    @(negedge clk);
    rd(3'd4, v); chk("R3 reload to zero", v, 0);
    rd(3'd5, v); chk("R3 wrap 255 to 0", v, 0);

    // R4: load while running wins over increment
    repeat (3) @(negedge clk);
    wr(3'd4, 7);
    rd(3'd4, v); chk("R4 count load beats counting", v, 7);

    // R5 / R6 / R7: capture
    start(1000, 999, 0, 1'b0, 0);
    repeat (int'($urandom % 20) + 3) @(negedge clk);
    rd(3'd4, v);
    sfd_in = 1'b1;
    @(negedge clk);
    rd(3'd6, v2); chk("R5 capture on frame start", v2, v);
    rd(3'd7, v2); chk("R5 flag set", v2, 1);
    wr(3'd7, 1);
    repeat (3) @(negedge clk);
    rd(3'd7, v2); chk("R6 R7 held level, flag cleared", v2, 0);
    rd(3'd6, v2); chk("R6 held level keeps capture", v2, v);
    txend_in = 1'b1; @(negedge clk); txend_in = 1'b0; @(negedge clk);
    rd(3'd7, v2); chk("R6 unselected source ignored (flag)", v2, 0);
    rd(3'd6, v2); chk("R6 unselected source ignored (capture)", v2, v);
    sfd_in = 1'b0;

    wr(3'd1, 3);
    repeat (5) @(negedge clk);
    rd(3'd4, v);
    txend_in = 1'b1;
    @(negedge clk);
    rd(3'd6, v2); chk("R5 capture on transmit end", v2, v);
    txend_in = 1'b0;
    @(negedge clk);
    sfd_in = 1'b1; @(negedge clk); sfd_in = 1'b0;
    rd(3'd6, v2); chk("R6 frame start ignored when tx end selected", v2, v);

    // R7: clear and capture in the same cycle, capture wins
    rd(3'd4, v);
    wr_en = 1'b1; wr_addr = 3'd7; wr_data = 16'd1; txend_in = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd(3'd7, v2); chk("R7 capture beats clear", v2, 1);
    rd(3'd6, v2); chk("R7 capture value", v2, v);
    wr(3'd7, 1);
    rd(3'd7, v2); chk("R7 clear", v2, 0);
    txend_in = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule